// File: doc/BRIEF.md
# UART Receive Byte Queue with Trigger and Character Timeout

This block holds received bytes between a UART's receive shifter and the host. The shifter gives it a one-cycle strobe with a byte, or a one-cycle break strobe. The host takes the oldest byte with a one-cycle data-read strobe. The byte being offered to the host is always present on `rd_byte`, so the read and the data that goes with it happen in the same cycle.

A FIFO-control write sets three things:
- whether the queue is on,
- the fill level at which the trigger flag rises,
- whether the queue is flushed.

When the queue is off, the block acts as a single holding register. The status outputs are data-ready, break, overrun, trigger-reached and a character-timeout pending flag. The parent sets the trigger flag up as the receive interrupt and the timeout flag as the timeout interrupt.

The timeout is counted in bit-time ticks from the baud logic. The limit is four character times, and the length of a character is worked out from the low four bits of the line-control setting. The timeout fires when data has sat in the queue with no push and no pop for that long.

Top module: `uart_rxq`

## Requirements
- R1: After reset the queue is off, holds nothing, and data_ready, brk_flag, ovr_flag, trig_hit, tmo_pend and rd_byte are all 0.
- R2: With the queue on, bytes leave in the order they arrived. `rd_byte` shows the oldest byte, and shows 0x00 when the queue is empty.
- R3: ctl_wdata[7:6] picks the trigger level: 00 is 1 byte, 01 is 4, 10 is 8, 11 is 14. With the queue on, trig_hit is 1 exactly when rx_level is at or above that level.
- R4: With the queue on and 16 bytes held, a byte that arrives without a read in the same cycle is dropped and ovr_flag is set. The level and the stored bytes do not change.
- R5: A break strobe stores a 0x00 byte and sets brk_flag and data_ready. If a data byte arrives in the same cycle, the break takes priority and that byte is not stored.
- R6: With the queue on and not empty, tmo_pend rises after 4 × (character bits) bit ticks in which nothing is pushed or popped. Every arriving byte and every host read restarts the count.
- R7: Character bits = 1 + (frame_fmt[1:0] + 5) + frame_fmt[3] + (frame_fmt[2] ? 2 : 1). These give 10 bits for 4'b0011, 12 for 4'b1111 and 7 for 4'b0000.
- R8: Every host read clears tmo_pend. The read that empties the queue clears data_ready and brk_flag.
- R9: A control write with bit 1 set empties the queue and clears data_ready, brk_flag and tmo_pend. A control write whose bit 0 differs from the current on/off state does the same, and also drives tx_flush. Bit 2 also drives tx_flush. Bit 0 becomes the new on/off state, shown on fifo_on.
- R10: With the queue off, a byte is kept in one holding register shown on rd_byte, and trig_hit follows data_ready. A byte that arrives while data_ready is set, with no read in that cycle, replaces the held byte and sets ovr_flag. A read clears data_ready.
- R11: An lsr_rd strobe clears brk_flag and ovr_flag, unless a new break or byte arrives in the same cycle.
- R12: A push and a pop in the same cycle leave rx_level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte_vld | input | 1 | One-cycle strobe: a byte was received |
| rx_byte | input | 8 | Received byte |
| rx_brk | input | 1 | One-cycle strobe: a break was detected |
| bit_tick | input | 1 | One pulse per bit time |
| frame_fmt | input | 4 | Line-control bits 3:0: data length, stop bits, parity enable |
| ctl_wr | input | 1 | FIFO-control write strobe |
| ctl_wdata | input | 8 | FIFO-control write value |
| host_rd | input | 1 | Host data-read strobe (pop) |
| lsr_rd | input | 1 | Host line-status read strobe |
| rd_byte | output | 8 | Byte offered to the host |
| data_ready | output | 1 | At least one byte is held |
| brk_flag | output | 1 | Break seen |
| ovr_flag | output | 1 | Overrun seen |
| trig_hit | output | 1 | Fill level has reached the trigger level |
| tmo_pend | output | 1 | Character timeout pending |
| fifo_on | output | 1 | Queue is on |
| tx_flush | output | 1 | Flush request to the transmit queue, valid in the write cycle |
| rx_level | output | 5 | Number of bytes held |

## Verification
The assertions assume the shifter's strobes and the host's read strobes last one cycle each. They also assume `frame_fmt` stays fixed while a timeout count is running; the timer's compare still ends a count if the format shrinks part way through. The bench only changes `frame_fmt` after a host read has restarted the count. It raises `bit_tick` only in the timeout tests, so a stray tick cannot cut short the character-time window that the other tests depend on. It never raises a data byte and a break together, except in the one test for R5 priority.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } trig_sel_e;

  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_RXR_BIT = 1;
  localparam int CTL_TXR_BIT = 2;
  localparam int MAX_FRAME_BITS = 12;

  function automatic logic [4:0] trig_level(input trig_sel_e sel);
    case (sel)
      TRIG_1:  return 5'd1;
      TRIG_4:  return 5'd4;
      TRIG_8:  return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  // start + data + optional parity + stop
  function automatic logic [3:0] frame_bits(input logic [3:0] fmt);
    logic [3:0] n;
    n = 4'd6 + {2'b00, fmt[1:0]};
    n = n + {3'b000, fmt[3]};
    n = n + (fmt[2] ? 4'd2 : 4'd1);
    return n;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      push,
  input  logic                      pop,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             head,
  output logic [$clog2(DEPTH):0]    level,
  output logic                      full,
  output logic                      empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] lvl_q, lvl_d;
  logic [DW-1:0] mem_q [DEPTH];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
    end else begin
      if (push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push, pop})
        2'b10:   lvl_d = lvl_q + 1'b1;
        2'b01:   lvl_d = lvl_q - 1'b1;
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem_q[wr_q] <= wdata;
  end

  assign head  = mem_q[rd_q];
  assign level = lvl_q;
  assign full  = (lvl_q == CW'(DEPTH));
  assign empty = (lvl_q == '0);

  // R4: never above capacity
  a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= CW'(DEPTH));
  // R4: the caller never writes into a full store without freeing a slot
  a_r4_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !clr) |-> pop);
  // R12: simultaneous push and pop hold the level
  a_r12_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !clr) |=> (level == $past(level)));
endmodule

// File: rtl/rxq_char_timer.sv
module rxq_char_timer #(
  parameter int CHARS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       restart,
  input  logic       run,
  input  logic [3:0] fbits,
  output logic       fire
);
  localparam int TW = $clog2(rxq_pkg::MAX_FRAME_BITS * CHARS + 1);

  logic [TW-1:0] cnt_q, cnt_d, lim;

  assign lim  = TW'(fbits) * TW'(CHARS);
  assign fire = run && !restart && tick && (cnt_q >= lim - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !run)  cnt_d = '0;
    else if (fire)        cnt_d = '0;
    else if (tick)        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6: any push or pop starts the count from zero
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  // R6: an idle timer does not advance
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && !tick) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/rxq_ctl.sv
module rxq_ctl
  import rxq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic      fifo_en,
  output trig_sel_e trig_sel,
  output logic      rx_clr,
  output logic      tx_clr
);
  logic      en_q, en_d;
  trig_sel_e sel_q, sel_d;
  logic      toggle;
  logic      ctl_unused;

  assign ctl_unused = ^ctl_wdata[5:3];
  assign toggle = ctl_wr && (ctl_wdata[CTL_EN_BIT] != en_q);
  assign rx_clr = (ctl_wr && ctl_wdata[CTL_RXR_BIT]) || toggle;
  assign tx_clr = (ctl_wr && ctl_wdata[CTL_TXR_BIT]) || toggle;

  always_comb begin
    en_d  = en_q;
    sel_d = sel_q;
    if (ctl_wr) begin
      en_d  = ctl_wdata[CTL_EN_BIT];
      sel_d = trig_sel_e'(ctl_wdata[7:6]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= TRIG_1;
    end else begin
      en_q  <= en_d;
      sel_q <= sel_d;
    end
  end

  assign fifo_en  = en_q;
  assign trig_sel = sel_q;

  // R9: a change of the enable bit always flushes both queues
  a_r9_toggle_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && (ctl_wdata[CTL_EN_BIT] != fifo_en)) |-> (rx_clr && tx_clr));
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import rxq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int DW        = 8,
  parameter int TMO_CHARS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_byte_vld,
  input  logic [DW-1:0]          rx_byte,
  input  logic                   rx_brk,
  input  logic                   bit_tick,
  input  logic [3:0]             frame_fmt,
  input  logic                   ctl_wr,
  input  logic [7:0]             ctl_wdata,
  input  logic                   host_rd,
  input  logic                   lsr_rd,
  output logic [DW-1:0]          rd_byte,
  output logic                   data_ready,
  output logic                   brk_flag,
  output logic                   ovr_flag,
  output logic                   trig_hit,
  output logic                   tmo_pend,
  output logic                   fifo_on,
  output logic                   tx_flush,
  output logic [$clog2(DEPTH):0] rx_level
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          fifo_en, rx_clr;
  trig_sel_e     trig_sel;
  logic [DW-1:0] head;
  logic [CW-1:0] lvl;
  logic          full, empty;

  logic          push_evt, f_pop, f_push, f_ovr, h_load, h_ovr, empt_rd;
  logic [DW-1:0] push_val;
  logic          fire, t_run, t_restart;

  logic          hv_q, hv_d;
  logic [DW-1:0] hold_q, hold_d;
  logic          brk_q, brk_d, ovr_q, ovr_d, tmo_q, tmo_d;

  rxq_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .fifo_en(fifo_en), .trig_sel(trig_sel), .rx_clr(rx_clr), .tx_clr(tx_flush)
  );

  // break takes priority over a data byte in the same cycle
  assign push_evt = rx_byte_vld || rx_brk;
  assign push_val = rx_brk ? '0 : rx_byte;

  assign f_pop  = fifo_en && host_rd && !empty;
  assign f_push = fifo_en && push_evt && (!full || f_pop);
  assign f_ovr  = fifo_en && push_evt && full && !f_pop;
  assign h_load = !fifo_en && push_evt;
  assign h_ovr  = h_load && hv_q && !host_rd;
  assign empt_rd = fifo_en ? (f_pop && (lvl == CW'(1)) && !f_push)
                           : host_rd;

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(f_push && !rx_clr), .pop(f_pop && !rx_clr), .wdata(push_val),
    .head(head), .level(lvl), .full(full), .empty(empty)
  );

  assign t_run     = fifo_en && !empty && !tmo_q;
  assign t_restart = push_evt || host_rd || rx_clr;

  rxq_char_timer #(.CHARS(TMO_CHARS)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .restart(t_restart),
    .run(t_run), .fbits(frame_bits(frame_fmt)), .fire(fire)
  );

  always_comb begin
    hv_d   = hv_q;
    hold_d = hold_q;
    brk_d  = brk_q;
    ovr_d  = ovr_q;
    tmo_d  = tmo_q;
    if (rx_clr) begin
      hv_d  = 1'b0;
      brk_d = 1'b0;
      tmo_d = 1'b0;
    end else begin
      if (h_load) begin
        hv_d   = 1'b1;
        hold_d = push_val;
      end else if (!fifo_en && host_rd) begin
        hv_d = 1'b0;
      end
      if (rx_brk)                 brk_d = 1'b1;
      else if (lsr_rd || empt_rd) brk_d = 1'b0;
      if (f_ovr || h_ovr)         ovr_d = 1'b1;
      else if (lsr_rd)            ovr_d = 1'b0;
      if (host_rd)                tmo_d = 1'b0;
      else if (fire)              tmo_d = 1'b1;
    end
    if (rx_clr && lsr_rd) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q   <= 1'b0;
      hold_q <= '0;
      brk_q  <= 1'b0;
      ovr_q  <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      hv_q   <= hv_d;
      hold_q <= hold_d;
      brk_q  <= brk_d;
      ovr_q  <= ovr_d;
      tmo_q  <= tmo_d;
    end
  end

  assign rd_byte    = fifo_en ? (empty ? '0 : head) : hold_q;
  assign data_ready = fifo_en ? !empty : hv_q;
  assign trig_hit   = fifo_en ? (int'(lvl) >= int'(trig_level(trig_sel))) : hv_q;
  assign brk_flag   = brk_q;
  assign ovr_flag   = ovr_q;
  assign tmo_pend   = tmo_q;
  assign fifo_on    = fifo_en;
  assign rx_level   = lvl;

  // R4: a dropped byte leaves level and oldest byte unchanged
  a_r4_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && full && push_evt && !host_rd && !rx_clr && !ctl_wr)
      |=> (ovr_flag && rx_level == $past(rx_level) && rd_byte == $past(rd_byte)));
  // R5: a break marks both break and data-ready
  a_r5_break_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_brk && !rx_clr && !ctl_wr) |=> (brk_flag && data_ready));
  // R8: a host read always drops the pending timeout
  a_r8_read_clears_tmo: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> !tmo_pend);
  // R9: a receive flush leaves nothing behind
  a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (rx_level == '0 && !data_ready && !brk_flag && !tmo_pend));
  // R11: a status read drops break and overrun when nothing new arrives
  a_r11_lsr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rx_brk && !rx_byte_vld) |=> (!brk_flag && !ovr_flag));
  // R6: a pending timeout always has data behind it
  a_r6_pend_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pend |-> data_ready);
endmodule

// File: tb/uart_rxq_tb.sv
module uart_rxq_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, rx_byte_vld, rx_brk, bit_tick, ctl_wr, host_rd, lsr_rd;
  logic [7:0] rx_byte, ctl_wdata, rd_byte;
  logic [3:0] frame_fmt;
  logic       data_ready, brk_flag, ovr_flag, trig_hit, tmo_pend, fifo_on, tx_flush;
  logic [4:0] rx_level;

  uart_rxq u_dut (
    .clk(clk), .rst_n(rst_n), .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
    .rx_brk(rx_brk), .bit_tick(bit_tick), .frame_fmt(frame_fmt),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .host_rd(host_rd), .lsr_rd(lsr_rd),
    .rd_byte(rd_byte), .data_ready(data_ready), .brk_flag(brk_flag),
    .ovr_flag(ovr_flag), .trig_hit(trig_hit), .tmo_pend(tmo_pend),
    .fifo_on(fifo_on), .tx_flush(tx_flush), .rx_level(rx_level)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] rd_seen;
  logic       flush_seen;
  logic [7:0] mq[$];

  // op[22:21] 1 push, 2 pop, 3 both; din[20:13]; expected rd_byte[12:5]; level[4:0]
  localparam logic [22:0] VEC [10] = '{
    {2'd1, 8'hA1, 8'h00, 5'd1},
    {2'd1, 8'hB2, 8'h00, 5'd2},
    {2'd1, 8'hC3, 8'h00, 5'd3},
    {2'd2, 8'h00, 8'hA1, 5'd2},
    {2'd1, 8'hD4, 8'h00, 5'd3},
    {2'd3, 8'hE5, 8'hB2, 5'd3},
    {2'd2, 8'h00, 8'hC3, 5'd2},
    {2'd2, 8'h00, 8'hD4, 5'd1},
    {2'd2, 8'h00, 8'hE5, 5'd0},
    {2'd2, 8'h00, 8'h00, 5'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at posedge+1; returns at next posedge+1
  task automatic cyc(input logic p, input logic [7:0] d, input logic b,
                     input logic r, input logic l, input logic t);
    rx_byte_vld = p; rx_byte = d; rx_brk = b; host_rd = r; lsr_rd = l; bit_tick = t;
    #1 rd_seen = rd_byte;
    @(posedge clk); #1;
    rx_byte_vld = 0; rx_brk = 0; host_rd = 0; lsr_rd = 0; bit_tick = 0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_wr = 1; ctl_wdata = v;
    #1 flush_seen = tx_flush;
    @(posedge clk); #1;
    ctl_wr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0, 0, 1);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 0; rx_byte_vld = 0; rx_byte = 0; rx_brk = 0; bit_tick = 0;
    frame_fmt = 4'b0011; ctl_wr = 0; ctl_wdata = 0; host_rd = 0; lsr_rd = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    chk("R1 fifo_on", fifo_on, 0);
    chk("R1 data_ready", data_ready, 0);
    chk("R1 flags", {brk_flag, ovr_flag, trig_hit, tmo_pend}, 0);
    chk("R1 rd_byte", rd_byte, 0);

    // R9 enabling toggles the enable bit: flush request
    wr_ctl(8'h01);
    chk("R9 enable flush", flush_seen, 1);
    chk("R9 fifo_on", fifo_on, 1);

    // R2 / R12 vector walk
    foreach (VEC[i]) begin
      logic [1:0] op;
      op = VEC[i][22:21];
      cyc(op[0], VEC[i][20:13], 0, op[1], 0, 0);
      if (op[1]) chk("R2 order", rd_seen, VEC[i][12:5]);
      chk(op == 2'd3 ? "R12 push+pop level" : "R2 level", rx_level, VEC[i][4:0]);
    end

    // R3 trigger levels
    wr_ctl(8'h41);
    chk("R9 no flush same enable", flush_seen, 0);
    for (int i = 0; i < 3; i++) begin cyc(1, 8'h10 + 8'(i), 0, 0, 0, 0); mq.push_back(8'h10 + 8'(i)); end
    chk("R3 level4 below", trig_hit, 0);
    cyc(1, 8'h13, 0, 0, 0, 0); mq.push_back(8'h13);
    chk("R3 level4 reached", trig_hit, 1);
    wr_ctl(8'h81);
    chk("R3 level8 below", trig_hit, 0);
    for (int i = 4; i < 8; i++) begin cyc(1, 8'h10 + 8'(i), 0, 0, 0, 0); mq.push_back(8'h10 + 8'(i)); end
    chk("R3 level8 reached", trig_hit, 1);
    wr_ctl(8'hC1);
    for (int i = 8; i < 13; i++) begin cyc(1, 8'h10 + 8'(i), 0, 0, 0, 0); mq.push_back(8'h10 + 8'(i)); end
    chk("R3 level14 below", trig_hit, 0);
    cyc(1, 8'h1D, 0, 0, 0, 0); mq.push_back(8'h1D);
    chk("R3 level14 reached", trig_hit, 1);
    wr_ctl(8'h01);
    chk("R3 level1", trig_hit, 1);

    // R4 overrun
    cyc(1, 8'h1E, 0, 0, 0, 0); mq.push_back(8'h1E);
    cyc(1, 8'h1F, 0, 0, 0, 0); mq.push_back(8'h1F);
    chk("R4 full level", rx_level, 16);
    chk("R4 no overrun yet", ovr_flag, 0);
    cyc(1, 8'hEE, 0, 0, 0, 0);
    chk("R4 overrun flag", ovr_flag, 1);
    chk("R4 level kept", rx_level, 16);
    chk("R4 head kept", rd_byte, 8'h10);
    cyc(0, 8'h00, 0, 0, 1, 0);
    chk("R11 overrun cleared", ovr_flag, 0);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] e;
      e = mq.pop_front();
      cyc(0, 8'h00, 0, 1, 0, 0);
      chk("R4 contents", rd_seen, e);
    end
    chk("R8 emptied", data_ready, 0);

    // R5 break
    cyc(1, 8'h55, 0, 0, 0, 0);
    cyc(0, 8'h00, 1, 0, 0, 0);
    chk("R5 break flag", brk_flag, 1);
    chk("R5 level", rx_level, 2);
    cyc(0, 8'h00, 0, 1, 0, 0);
    chk("R5 first byte", rd_seen, 8'h55);
    chk("R8 break kept while data", brk_flag, 1);
    cyc(0, 8'h00, 0, 1, 0, 0);
    chk("R5 zero byte", rd_seen, 8'h00);
    chk("R8 empty clears break", {brk_flag, data_ready}, 0);
    cyc(1, 8'h77, 1, 0, 0, 0);
    chk("R5 priority level", rx_level, 1);
    chk("R5 priority byte", rd_byte, 8'h00);
    cyc(0, 8'h00, 0, 0, 1, 0);
    chk("R11 break cleared", brk_flag, 0);
    chk("R11 data kept", data_ready, 1);
    cyc(0, 8'h00, 0, 1, 0, 0);

    // R6 / R7 timeout, 8N1 = 10 bits -> 40 ticks
    frame_fmt = 4'b0011;
    cyc(1, 8'h61, 0, 0, 0, 0);
    ticks(39);
    chk("R6 R7 10bit before", tmo_pend, 0);
    ticks(1);
    chk("R6 R7 10bit fire", tmo_pend, 1);
    cyc(0, 8'h00, 0, 1, 0, 0);
    chk("R8 read clears tmo", tmo_pend, 0);

    // 12 bits -> 48 ticks, restart on push
    frame_fmt = 4'b1111;
    cyc(1, 8'h62, 0, 0, 0, 0);
    cyc(1, 8'h63, 0, 0, 0, 0);
    ticks(30);
    cyc(1, 8'h64, 0, 0, 0, 0);
    ticks(47);
    chk("R6 restart on push", tmo_pend, 0);
    ticks(1);
    chk("R7 12bit fire", tmo_pend, 1);
    cyc(0, 8'h00, 0, 1, 0, 0);
    chk("R8 tmo cleared", tmo_pend, 0);
    ticks(47);
    chk("R6 restart on pop", tmo_pend, 0);
    ticks(1);
    chk("R6 fire after pop", tmo_pend, 1);
    cyc(0, 8'h00, 0, 1, 0, 0);
    frame_fmt = 4'b0000;
    ticks(27);
    chk("R7 7bit before", tmo_pend, 0);
    ticks(1);
    chk("R7 7bit fire", tmo_pend, 1);

    // R9 receive flush
    cyc(1, 8'h65, 0, 0, 0, 0);
    wr_ctl(8'h07);
    chk("R9 flush level", rx_level, 0);
    chk("R9 flush flags", {data_ready, tmo_pend, brk_flag}, 0);
    chk("R9 tx bit", flush_seen, 1);
    ticks(60);
    chk("R9 timer stopped", tmo_pend, 0);
    cyc(1, 8'h66, 0, 0, 0, 0);
    cyc(1, 8'h67, 0, 0, 0, 0);
    wr_ctl(8'h00);
    chk("R9 disable flush", flush_seen, 1);
    chk("R9 disable empties", {fifo_on, data_ready}, 0);

    // R10 holding register
    cyc(1, 8'h31, 0, 0, 0, 0);
    chk("R10 ready", {data_ready, trig_hit}, 2'b11);
    chk("R10 byte", rd_byte, 8'h31);
    cyc(1, 8'h32, 0, 0, 0, 0);
    chk("R10 overrun", ovr_flag, 1);
    chk("R10 replaced", rd_byte, 8'h32);
    cyc(0, 8'h00, 0, 1, 0, 0);
    chk("R10 read value", rd_seen, 8'h32);
    chk("R10 read clears", data_ready, 0);
    cyc(0, 8'h00, 0, 0, 1, 0);
    chk("R11 overrun cleared", ovr_flag, 0);

    summary();
  end
endmodule